// File: doc/BRIEF.md
# Row/Column Video Memory Access Port

This block gives a slow processor a narrow window onto a separate video RAM. Instead of mapping the frame buffer into the processor's address space, the processor sees four byte-wide registers: a column, a row, a data port and a control register. The block turns the row/column position into a linear cell address (row times the grid width plus column) and runs the RAM access itself. It can move the position by one cell after each data access, along either axis and in either direction, with wrap-around at the grid edges.

The video RAM belongs to the display while the picture is drawn, so the block only touches it while the `blank` input is high. A data write is held in a single pending slot until blanking arrives. The byte at the current position is fetched ahead of time into a read latch. It is refetched whenever the position changes or a write commits, so a read of the data port returns it at once. The control register shows whether an access is still outstanding, and it flags a write that was refused because the slot was full.

Top module: `vidmem_regport`

## Requirements
- R1: After reset the column, row, control and data registers read 0, and neither `vram_we` nor `vram_re` is asserted.
- R2: Register select 0 is the column, 1 is the row, 2 is the data port and 3 is control. Column and row read back the last accepted value, zero-extended. Control bits [2:0] read back as written, and bits [7:5] read 0.
- R3: A column write of 80 or more, or a row write of 60 or more, is ignored and leaves that position register unchanged.
- R4: A data write produces exactly one `vram_we` cycle, with `vram_addr` = row*80+column taken at the time of the write and `vram_wdata` = the written byte. It is held for as long as `blank` is low and commits in a cycle in which `blank` is high.
- R5: A data write while an earlier write is still pending is dropped and sets control bit 4. Bit 4 stays set until the control register is written. Control bit 3 reads 1 while any write or fetch is outstanding.
- R6: With control bit 0 set, the position moves one cell after a data write commits, and the committed address is the position from before the move. Bit 1 selects the axis (0 column, 1 row) and bit 2 selects the direction (0 increment, 1 decrement).
- R7: Stepping wraps within its axis: column 79 to 0 and 0 to 79, row 59 to 0 and 0 to 59. The other coordinate is unchanged.
- R8: After a position change or a write commit, the block asserts `vram_re` during blanking, when no write is pending, at the current row*80+column. It captures `vram_rdata` on the cycle after `vram_re`, and data-port reads return the captured byte.
- R9: A data-port read returns the latched byte. With bit 0 set, it then steps the position as in R6 and queues a fetch at the new position.
- R10: `vram_we` and `vram_re` are never asserted while `blank` is low, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| blank | input | 1 | High while the display leaves the RAM free |
| vram_we | output | 1 | Video RAM write enable |
| vram_re | output | 1 | Video RAM read enable |
| vram_addr | output | 13 | Video RAM cell address |
| vram_wdata | output | 8 | Video RAM write data |
| vram_rdata | input | 8 | Video RAM read data, valid the cycle after `vram_re` |

## Verification
The assertions check on every cycle that no RAM strobe occurs outside blanking and that the two strobes never overlap. They also check that a pending write keeps its address until it commits, that positions stay inside the grid and wrap correctly at the edges, and that the refusal flag is sticky. Only the bench scenarios can show the end-to-end results. These include the linear address a write lands on, that the address committed is the one from before the step, that the fetched byte surfaces on a data read, and that out-of-range position writes leave the registers untouched.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEL_COL  = 2'd0,
    SEL_ROW  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // control register bit positions
  localparam int CB_STEP = 0;
  localparam int CB_AXIS = 1;
  localparam int CB_DIR  = 2;
  localparam int CB_PEND = 3;
  localparam int CB_REJ  = 4;

  // linear cell index of a grid position
  function automatic int unsigned cell_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction

  // one step along an axis of length lim, wrapping at both ends
  function automatic int unsigned wrap_step(input int unsigned v,
                                            input int unsigned lim,
                                            input logic        dec);
    if (dec) return (v == 0) ? lim - 1 : v - 1;
    return (v == lim - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/vrp_position.sv
module vrp_position #(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     col_we,
  input  logic                     row_we,
  input  logic [vrp_pkg::BUS_W-1:0] wdata,
  input  logic                     step_req,
  input  logic                     axis_row,
  input  logic                     dec,
  output logic [CW-1:0]            col,
  output logic [RW-1:0]            row,
  output logic                     moved
);
  import vrp_pkg::*;

  logic col_ok, row_ok, step_col, step_row;
  logic [CW-1:0] col_stepped;
  logic [RW-1:0] row_stepped;

  // writes outside the grid are dropped (R3)
  assign col_ok   = col_we && (int'(wdata) < COLS);
  assign row_ok   = row_we && (int'(wdata) < ROWS);
  assign step_col = step_req && !axis_row;
  assign step_row = step_req &&  axis_row;

  assign col_stepped = CW'(wrap_step(int'(col), COLS, dec));
  assign row_stepped = RW'(wrap_step(int'(row), ROWS, dec));

  assign moved = col_ok || row_ok || step_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      if (col_ok)        col <= CW'(wdata);
      else if (step_col) col <= col_stepped;
      if (row_ok)        row <= RW'(wdata);
      else if (step_row) row <= row_stepped;
    end
  end

  a_r7_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) < COLS);
  a_r7_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) < ROWS);
  a_r7_col_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_col && !dec && !col_we && (int'(col) == COLS - 1) |=> col == '0);
  a_r7_col_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    step_col && dec && !col_we && col == '0 |=> int'(col) == COLS - 1);
  a_r7_row_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_row && !dec && !row_we && (int'(row) == ROWS - 1) |=> row == '0);
  a_r7_row_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    step_row && dec && !row_we && row == '0 |=> int'(row) == ROWS - 1);
  a_r7_other_axis_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step_col && !row_we |=> $stable(row));

endmodule

// File: rtl/vrp_access.sv
module vrp_access #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pos_moved,
  input  logic [AW-1:0] cur_addr,
  input  logic          clr_rej,
  input  logic [DW-1:0] vram_rdata,
  output logic          vram_we,
  output logic          vram_re,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata,
  output logic [DW-1:0] rd_latch,
  output logic          commit,
  output logic          pending,
  output logic          reject
);

  logic          wr_pend, fetch_due, fetch_wait;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic          wr_take, wr_refused, fetch_issue;

  // named events for the assertions
  assign wr_take     = wr_req && !wr_pend;
  assign wr_refused  = wr_req &&  wr_pend;
  assign commit      = wr_pend && blank;
  assign fetch_issue = fetch_due && blank && !wr_pend;

  assign vram_we    = commit;
  assign vram_re    = fetch_issue;
  assign vram_addr  = commit ? wr_addr_q : cur_addr;
  assign vram_wdata = wr_data_q;
  assign pending    = wr_pend || fetch_due || fetch_wait;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pend    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      fetch_due  <= 1'b0;
      fetch_wait <= 1'b0;
      rd_latch   <= '0;
      reject     <= 1'b0;
    end else begin
      if (wr_take) begin
        wr_pend   <= 1'b1;
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
      end else if (commit) begin
        wr_pend <= 1'b0;
      end
      fetch_due  <= pos_moved || commit || (fetch_due && !fetch_issue);
      fetch_wait <= fetch_issue;
      if (fetch_wait) rd_latch <= vram_rdata;
      if (wr_refused)   reject <= 1'b1;
      else if (clr_rej) reject <= 1'b0;
    end
  end

  a_r10_we_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> blank);
  a_r10_re_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |-> blank);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_we && vram_re));
  a_r4_pending_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && !blank |=> $stable(wr_addr_q) && $stable(wr_data_q));
  a_r4_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |=> !vram_we);
  a_r5_reject_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !clr_rej |=> reject);
  a_r5_refused_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refused |=> reject);
  a_r8_latch_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |=> pending);

endmodule

// File: rtl/vidmem_regport.sv
module vidmem_regport #(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS),
  localparam int DW = vrp_pkg::BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          blank,
  output logic          vram_we,
  output logic          vram_re,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata,
  input  logic [DW-1:0] vram_rdata
);
  import vrp_pkg::*;

  sel_e          sel;
  logic [2:0]    ctrl_q;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_latch;
  logic          moved, commit, pending, reject;
  logic          col_we, row_we, data_we, ctrl_we, data_rd, step_req;

  assign sel     = sel_e'(bus_sel);
  assign col_we  = bus_wr && (sel == SEL_COL);
  assign row_we  = bus_wr && (sel == SEL_ROW);
  assign data_we = bus_wr && (sel == SEL_DATA);
  assign ctrl_we = bus_wr && (sel == SEL_CTRL);
  assign data_rd = bus_rd && (sel == SEL_DATA);

  // step only once the access has been carried out (R6, R9)
  assign step_req = ctrl_q[CB_STEP] && (commit || data_rd);
  assign cur_addr = AW'(cell_index(int'(row), int'(col), COLS));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[2:0];
  end

  vrp_position #(.COLS(COLS), .ROWS(ROWS)) pos_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_we   (col_we),
    .row_we   (row_we),
    .wdata    (bus_wdata),
    .step_req (step_req),
    .axis_row (ctrl_q[CB_AXIS]),
    .dec      (ctrl_q[CB_DIR]),
    .col      (col),
    .row      (row),
    .moved    (moved)
  );

  vrp_access #(.AW(AW), .DW(DW)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .wr_req     (data_we),
    .wr_addr    (cur_addr),
    .wr_data    (bus_wdata),
    .pos_moved  (moved),
    .cur_addr   (cur_addr),
    .clr_rej    (ctrl_we),
    .vram_rdata (vram_rdata),
    .vram_we    (vram_we),
    .vram_re    (vram_re),
    .vram_addr  (vram_addr),
    .vram_wdata (vram_wdata),
    .rd_latch   (rd_latch),
    .commit     (commit),
    .pending    (pending),
    .reject     (reject)
  );

  always_comb begin
    unique case (sel)
      SEL_COL:  bus_rdata = DW'(col);
      SEL_ROW:  bus_rdata = DW'(row);
      SEL_DATA: bus_rdata = rd_latch;
      SEL_CTRL: bus_rdata = DW'({reject, pending, ctrl_q});
      default:  bus_rdata = '0;
    endcase
  end

  a_r6_step_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl_q[CB_STEP] && !bus_wr |=> !$stable(cur_addr) || (COLS == 1) || (ROWS == 1));
  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_CTRL |-> bus_rdata[DW-1:5] == '0);
  a_r1_no_strobe_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !vram_we && !vram_re);

endmodule

// File: tb/vidmem_regport_tb_top.sv
module vidmem_regport_tb_top;
  localparam int COLS = 80;
  localparam int ROWS = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       blank = 1'b0;
  logic       vram_we, vram_re;
  logic [12:0] vram_addr;
  logic [7:0] vram_wdata;
  logic [7:0] vram_rdata = '0;

  int checks = 0, failures = 0;
  int wr_count = 0, last_addr = -1, last_data = -1, viol = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vidmem_regport #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .blank(blank),
    .vram_we(vram_we), .vram_re(vram_re), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata));

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + (a >> 8) + 11);
  endfunction

  // video RAM model and strobe monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (vram_re) vram_rdata <= pat(int'(vram_addr));
      if ((vram_we || vram_re) && !blank) viol++;
      if (vram_we && vram_re) viol++;
      if (vram_we) begin
        wr_count++;
        last_addr = int'(vram_addr);
        last_data = int'(vram_wdata);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bwrite(input int s, input int d);
    @(negedge clk);
    bus_sel = 2'(s); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input int s, output int d);
    @(negedge clk);
    bus_sel = 2'(s); bus_rd = 1'b1;
    #2 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 40; i++) begin
      bread(3, v);
      if (v[3] == 0) return;
    end
    chk("R5", "idle timeout", 1, 0);
  endtask

  initial begin
    int v, c, r, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      bread(s, v);
      chk("R1", "reset register", v, 0);
    end
    chk("R1", "no write after reset", wr_count, 0);

    // R2 readback sweeps
    for (int i = 0; i < COLS; i++) begin
      bwrite(0, i); bread(0, v);
      chk("R2", "column readback", v, i);
    end
    for (int i = 0; i < ROWS; i++) begin
      bwrite(1, i); bread(1, v);
      chk("R2", "row readback", v, i);
    end
    blank = 1'b1;
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      bwrite(3, i | 8'he0); bread(3, v);
      chk("R2", "control readback", v, i);
    end
    bwrite(3, 0);

    // R3 out-of-range writes ignored
    bwrite(0, 33); bwrite(1, 21);
    for (int i = 80; i < 256; i += 7) begin
      bwrite(0, i); bread(0, v);
      chk("R3", "column kept", v, 33);
    end
    for (int i = 60; i < 256; i += 13) begin
      bwrite(1, i); bread(1, v);
      chk("R3", "row kept", v, 21);
    end

    // R4 write held until blanking, then at row*80+col
    wait_idle();
    blank = 1'b0;
    bwrite(0, 5); bwrite(1, 7);
    k = wr_count;
    bwrite(2, 8'ha5);
    repeat (6) @(negedge clk);
    chk("R4", "held while active", wr_count, k);
    bread(3, v);
    chk("R5", "pending bit", v[3], 1);
    blank = 1'b1;
    wait_idle();
    chk("R4", "one write", wr_count, k + 1);
    chk("R4", "address", last_addr, 7 * 80 + 5);
    chk("R4", "data", last_data, 8'ha5);
    for (int i = 0; i < 12; i++) begin
      c = (i * 29) % COLS; r = (i * 17 + 59) % ROWS;
      bwrite(0, c); bwrite(1, r); bwrite(2, i + 100);
      wait_idle();
      chk("R4", "sweep address", last_addr, r * 80 + c);
      chk("R4", "sweep data", last_data, i + 100);
    end

    // R5 refused second write
    blank = 1'b0;
    bwrite(0, 2); bwrite(1, 3);
    k = wr_count;
    bwrite(2, 8'h11); bwrite(2, 8'h22);
    bread(3, v);
    chk("R5", "reject and pending", v & 8'h18, 8'h18);
    blank = 1'b1;
    wait_idle();
    chk("R5", "only first committed", wr_count, k + 1);
    chk("R5", "first data kept", last_data, 8'h11);
    bread(3, v);
    chk("R5", "reject sticky", v[4], 1);
    bwrite(3, 0); bread(3, v);
    chk("R5", "reject cleared", v[4], 0);

    // R6/R7 step column up across wrap
    bwrite(0, 78); bwrite(1, 3); bwrite(3, 8'h01);
    for (int i = 0; i < 3; i++) begin
      bwrite(2, 40 + i); wait_idle();
      chk("R6", "pre-step address", last_addr, 3 * 80 + (78 + i) % 80);
    end
    bread(0, v); chk("R7", "column wrapped up", v, 1);
    bread(1, v); chk("R7", "row untouched", v, 3);
    // column down across wrap
    bwrite(0, 1); bwrite(3, 8'h05);
    for (int i = 0; i < 3; i++) begin
      bwrite(2, 50 + i); wait_idle();
      chk("R6", "decrement address", last_addr, 3 * 80 + (81 - i) % 80);
    end
    bread(0, v); chk("R7", "column wrapped down", v, 78);
    // row down across wrap
    bwrite(0, 9); bwrite(1, 1); bwrite(3, 8'h07);
    for (int i = 0; i < 3; i++) begin
      bwrite(2, 60 + i); wait_idle();
      chk("R6", "row step address", last_addr, ((61 - i) % 60) * 80 + 9);
    end
    bread(1, v); chk("R7", "row wrapped down", v, 58);
    bread(0, v); chk("R7", "column untouched", v, 9);
    // row up across wrap
    bwrite(1, 59); bwrite(3, 8'h03);
    bwrite(2, 1); wait_idle();
    chk("R6", "row up address", last_addr, 59 * 80 + 9);
    bread(1, v); chk("R7", "row wrapped up", v, 0);
    bwrite(3, 0);

    // R8 fetch surfaces on data read
    for (int i = 0; i < ROWS; i++) begin
      c = (i * 7) % COLS;
      bwrite(1, i); bwrite(0, c);
      wait_idle();
      bread(2, v);
      chk("R8", "fetched byte", v, int'(pat(i * 80 + c)));
    end
    bwrite(0, 79); bwrite(1, 59); wait_idle();
    bread(2, v);
    chk("R8", "last cell", v, int'(pat(4799)));

    // R9 data reads step and refetch
    bwrite(0, 76); bwrite(1, 2); bwrite(3, 8'h01); wait_idle();
    for (int i = 0; i < 6; i++) begin
      bread(2, v);
      chk("R9", "streamed read", v, int'(pat(2 * 80 + (76 + i) % 80)));
      wait_idle();
    end
    bread(0, v); chk("R9", "column after reads", v, 2);
    bwrite(3, 0);

    // R10 strobes only in blanking, never together
    chk("R10", "strobe violations", viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule